// File: doc/BRIEF.md
# Programmable Tick Divider with Stop Control

This block derives a slower tick stream from one of several source tick inputs. Every source is a single-cycle enable pulse in the system clock domain. The block counts pulses on the chosen source and emits one output pulse for every programmed number of source pulses. The ratio runs from 1 to 64. A single 32-bit control word holds the ratio, a stop flag and, in the multi-source variants, the source index. The word is written and read through a plain write-enable port.

An elaboration parameter picks the variant: one fixed source, four sources or eight sources. The position of the source-index field depends on the variant. While stopped, the block produces no output pulses and its divisor field is never zero. Any change to the ratio or to the source, and any stop period, restarts the count. The first output pulse after such a change therefore comes a full period later.

Top module: `prog_tick_divider`

## Requirements
- R1: Control bits 5:0 hold a value N. While running, one output pulse is produced on every (N+1)-th pulse of the selected source, which gives ratios 1 to 64.
- R2: With N = 0 and the block running, tick_out equals the selected source pulse in the same cycle.
- R3: While control bit 8 (stop) is set, tick_out stays low whatever the sources do.
- R4: running is high exactly when control bit 8 is clear.
- R5: The eight-source variant takes the source index from bits 14:12, the four-source variant from bits 7:6, and the fixed variant always uses source 0. Pulses on sources that are not selected have no effect on tick_out.
- R6: A write with bit 8 set and bits 5:0 equal to zero is stored with bits 5:0 forced to 6'h3F. The stored word never has bit 8 set with a zero divisor.
- R7: A write that changes the divisor or the source index restarts the count, and so does a stop period. The next output pulse then comes on the (N+1)-th following source pulse.
- R8: Bits outside the divisor, stop and source-index fields of the chosen variant read as zero, and writes to them are ignored.
- R9: After reset the control word reads 0x0000013F: stopped, divisor 6'h3F, source 0.
- R10: A write with wr_en high updates rd_data from the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 32 | Control-word write value |
| rd_data | output | 32 | Stored control word |
| src_tick | input | SRC_COUNT | Source tick pulses, one bit per source |
| tick_out | output | 1 | Divided output tick |
| running | output | 1 | High while the divider is not stopped |

## Verification
The bound checker checks on every cycle that no output pulse appears while stopped and that the running flag mirrors the stop bit. It also checks that a stopped word never carries a zero divisor, that undefined bits stay zero, that every output pulse coincides with a pulse on the selected source, that ratio one passes pulses straight through, and that a plain write reaches the register one edge later. Pulse counts for a given ratio, the isolation of unselected sources, and the full-period delay after a restart depend on a history of source pulses. Only the bench's scenarios show these.

// File: rtl/tdiv_pkg.sv
package tdiv_pkg;

    localparam int WORD_W   = 32;
    localparam int DIV_W    = 6;
    localparam int SEL_MAXW = 3;
    localparam int STOP_POS = 8;

    typedef struct packed {
        logic                stop;
        logic [SEL_MAXW-1:0] sel;
        logic [DIV_W-1:0]    div;
    } ctrl_t;

    function automatic int sel_lsb(input int src_count);
        if (src_count == 8)      return 12;
        else if (src_count == 4) return 6;
        else                     return 0;
    endfunction

    function automatic int sel_width(input int src_count);
        if (src_count == 8)      return 3;
        else if (src_count == 4) return 2;
        else                     return 0;
    endfunction

    function automatic logic [WORD_W-1:0] defined_mask(input int src_count);
        logic [WORD_W-1:0] m;
        m = WORD_W'((1 << DIV_W) - 1) | (WORD_W'(1) << STOP_POS);
        m = m | (WORD_W'((1 << sel_width(src_count)) - 1) << sel_lsb(src_count));
        return m;
    endfunction

    function automatic ctrl_t unpack_word(input logic [WORD_W-1:0] w, input int src_count);
        ctrl_t c;
        c.div  = w[DIV_W-1:0];
        c.stop = w[STOP_POS];
        c.sel  = SEL_MAXW'((w >> sel_lsb(src_count)) &
                           WORD_W'((1 << sel_width(src_count)) - 1));
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input ctrl_t c, input int src_count);
        logic [WORD_W-1:0] w;
        w = WORD_W'(c.div) | (WORD_W'(c.stop) << STOP_POS);
        if (sel_width(src_count) > 0)
            w = w | (WORD_W'(c.sel) << sel_lsb(src_count));
        return w;
    endfunction

    function automatic ctrl_t force_nonzero(input ctrl_t c);
        ctrl_t r;
        r = c;
        if (c.stop && (c.div == '0))
            r.div = '1;
        return r;
    endfunction

    localparam ctrl_t CTRL_RESET = '{stop: 1'b1, sel: '0, div: '1};

endpackage

// File: rtl/tdiv_ctrl_reg.sv
module tdiv_ctrl_reg
    import tdiv_pkg::*;
#(
    parameter int SRC_COUNT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic              restart
);
    ctrl_t next_ctrl;

    always_comb begin
        next_ctrl = force_nonzero(unpack_word(wr_data, SRC_COUNT));
        restart   = wr_en && ((next_ctrl.div != ctrl.div) || (next_ctrl.sel != ctrl.sel));
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= CTRL_RESET;
        else if (wr_en)
            ctrl <= next_ctrl;
    end
endmodule

// File: rtl/tdiv_src_mux.sv
module tdiv_src_mux
    import tdiv_pkg::*;
#(
    parameter int SRC_COUNT = 8
) (
    input  logic [SRC_COUNT-1:0] src_tick,
    input  logic [SEL_MAXW-1:0]  sel,
    output logic                 sel_tick
);
    localparam int SW = (sel_width(SRC_COUNT) > 0) ? sel_width(SRC_COUNT) : 1;

    generate
        if (SRC_COUNT == 1) begin : g_fixed
            logic unused_sel;
            assign unused_sel = ^sel;
            assign sel_tick   = src_tick[0];
        end else begin : g_multi
            logic [SW-1:0] idx;
            assign idx      = sel[SW-1:0];
            assign sel_tick = src_tick[idx];
        end
    endgenerate
endmodule

// File: rtl/tdiv_tick_count.sv
module tdiv_tick_count
    import tdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             stop,
    input  logic [DIV_W-1:0] div,
    input  logic             sel_tick,
    output logic             tick_out
);
    logic [DIV_W-1:0] cnt;
    logic             at_end;

    assign at_end   = (cnt >= div);
    assign tick_out = sel_tick && !stop && at_end;

    always_ff @(posedge clk) begin
        if (rst || stop || restart)
            cnt <= '0;
        else if (sel_tick)
            cnt <= at_end ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/prog_tick_divider.sv
module prog_tick_divider
    import tdiv_pkg::*;
#(
    parameter int SRC_COUNT = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [31:0]          wr_data,
    output logic [31:0]          rd_data,
    input  logic [SRC_COUNT-1:0] src_tick,
    output logic                 tick_out,
    output logic                 running
);
    ctrl_t ctrl;
    logic  restart;
    logic  sel_tick;

    tdiv_ctrl_reg #(.SRC_COUNT(SRC_COUNT)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .restart (restart)
    );

    tdiv_src_mux #(.SRC_COUNT(SRC_COUNT)) u_mux (
        .src_tick (src_tick),
        .sel      (ctrl.sel),
        .sel_tick (sel_tick)
    );

    tdiv_tick_count u_cnt (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .stop     (ctrl.stop),
        .div      (ctrl.div),
        .sel_tick (sel_tick),
        .tick_out (tick_out)
    );

    assign rd_data = pack_word(ctrl, SRC_COUNT);
    assign running = !ctrl.stop;
endmodule

// File: rtl/tdiv_checker.sv
module tdiv_checker
    import tdiv_pkg::*;
#(
    parameter int SRC_COUNT = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic [31:0]          wr_data,
    input logic [31:0]          rd_data,
    input logic [SRC_COUNT-1:0] src_tick,
    input logic                 tick_out,
    input logic                 running
);
    localparam logic [31:0] MASK = defined_mask(SRC_COUNT);

    ctrl_t seen;
    logic  chosen;
    always_comb begin
        seen   = unpack_word(rd_data, SRC_COUNT);
        chosen = 1'b0;
        for (int i = 0; i < SRC_COUNT; i++)
            if (32'(i) == 32'(seen.sel))
                chosen = src_tick[i];
    end

    p_stop_silent_r3: assert property (@(posedge clk) disable iff (rst)
        rd_data[8] |-> !tick_out);

    p_running_r4: assert property (@(posedge clk) disable iff (rst)
        running == !rd_data[8]);

    p_stop_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
        rd_data[8] |-> (rd_data[5:0] != 6'd0));

    p_undef_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~MASK) == 32'd0);

    p_passthru_r2: assert property (@(posedge clk) disable iff (rst)
        (!rd_data[8] && rd_data[5:0] == 6'd0) |-> (tick_out == chosen));

    p_needs_src_r5: assert property (@(posedge clk) disable iff (rst)
        tick_out |-> chosen);

    p_write_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[8]) |=> (rd_data == ($past(wr_data) & MASK)));
endmodule

bind prog_tick_divider tdiv_checker #(.SRC_COUNT(SRC_COUNT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .src_tick (src_tick),
    .tick_out (tick_out),
    .running  (running)
);

// File: tb/test_prog_tick_divider.sv
`timescale 1ns/1ps
module test_prog_tick_divider;
    localparam int SRC = 8;

    logic           clk = 1'b0;
    logic           rst;
    logic           wr_en;
    logic [31:0]    wr_data;
    logic [31:0]    rd_data;
    logic [SRC-1:0] src_tick;
    logic           tick_out;
    logic           running;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    prog_tick_divider #(.SRC_COUNT(SRC)) i_prog_tick_divider (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .src_tick(src_tick), .tick_out(tick_out), .running(running)
    );

    // vector: {word, source pulsed, pulse count, expected output ticks}
    typedef struct packed {
        logic [31:0] word;
        logic [31:0] src;
        logic [31:0] n;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{32'h0000_0000, 32'd0, 32'd5,   32'd5},  // R2 ratio 1
        '{32'h0000_0003, 32'd0, 32'd12,  32'd3},  // R1 ratio 4
        '{32'h0000_003F, 32'd0, 32'd128, 32'd2},  // R1 ratio 64
        '{32'h0000_5002, 32'd5, 32'd9,   32'd3},  // R5 source 5
        '{32'h0000_5002, 32'd3, 32'd9,   32'd0},  // R5 unselected source
        '{32'h0000_7001, 32'd7, 32'd7,   32'd3},  // R5 source 7, ratio 2
        '{32'h0000_0105, 32'd0, 32'd12,  32'd0},  // R3 stopped
        '{32'h0000_2004, 32'd2, 32'd10,  32'd2}   // R1 ratio 5, source 2
    };

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [31:0] w);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = 32'd0;
    endtask

    // pulses one source n times with a gap cycle; returns output tick count
    // and the 1-based pulse index of the first output tick (0 if none)
    task automatic pulse(input int idx, input int n, output int hits, output int first);
        hits  = 0;
        first = 0;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            src_tick = '0;
            src_tick[idx] = 1'b1;
            #1;
            if (tick_out) begin
                hits++;
                if (first == 0) first = k;
            end
            @(negedge clk);
            src_tick = '0;
        end
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int h, f;
        rst = 1'b1; wr_en = 1'b0; wr_data = '0; src_tick = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        check(rd_data == 32'h13F, "R9 reset word", rd_data, 32'h13F);
        check(running == 1'b0, "R4 running after reset", running, 0);
        pulse(0, 70, h, f);
        check(h == 0, "R3 no ticks while stopped from reset", h, 0);

        for (int v = 0; v < 8; v++) begin
            write_reg(VECS[v].word);
            check(rd_data == VECS[v].word, "R10 written word", rd_data, VECS[v].word);
            check(running == !VECS[v].word[8], "R4 running flag", running, !VECS[v].word[8]);
            pulse(int'(VECS[v].src), int'(VECS[v].n), h, f);
            check(h == int'(VECS[v].exp), "R1 R5 R3 output tick count", h, VECS[v].exp);
        end

        // R7: divisor change restarts the count
        write_reg(32'h0000_0003);
        pulse(0, 2, h, f);
        check(h == 0, "R7 partial count", h, 0);
        write_reg(32'h0000_0004);
        pulse(0, 5, h, f);
        check(f == 5 && h == 1, "R7 full period after divisor change", f, 5);

        // R7: stop period restarts the count
        pulse(0, 3, h, f);
        write_reg(32'h0000_0104);
        write_reg(32'h0000_0004);
        pulse(0, 5, h, f);
        check(f == 5 && h == 1, "R7 full period after stop", f, 5);

        // R6: stop with zero divisor
        write_reg(32'h0000_0100);
        check(rd_data == 32'h13F, "R6 forced divisor", rd_data, 32'h13F);
        write_reg(32'h0000_6100);
        check(rd_data == 32'h613F, "R6 forced divisor with source", rd_data, 32'h613F);

        // R8: undefined bits
        write_reg(32'hFFFF_FFFF);
        check(rd_data == 32'h713F, "R8 all ones write", rd_data, 32'h713F);
        write_reg(32'h0000_80C5);
        check(rd_data == 32'h0000_0005, "R8 undefined bits ignored", rd_data, 32'h5);
        check(running == 1'b1, "R4 running after clear", running, 1);

        // R2 on source 6 with an unselected source pulsing
        write_reg(32'h0000_6000);
        pulse(1, 4, h, f);
        check(h == 0, "R5 unselected source with ratio 1", h, 0);
        pulse(6, 4, h, f);
        check(h == 4, "R2 pass-through source 6", h, 4);

        // R9: reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(rd_data == 32'h13F, "R9 reset while running", rd_data, 32'h13F);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule